// File: doc/BRIEF.md
# Triplex Windowed Majority Voter

This block merges three redundant copies of one measured quantity, each produced by an independent channel and announced by a one-cycle strobe, into a single voted value. Because the channels sample at slightly different instants, their values are never exactly equal. Two channels therefore count as agreeing when their values differ by at most a tolerance taken from an input port. A channel is declared faulty only when both of its peers disagree with it. Whenever one of the two peers agrees with a channel, that channel is trusted.

A round begins with the first strobe and ends when all three channels have delivered a value. The vote is registered on the following clock. If a channel stays silent for a bounded number of cycles, the round closes without it and that channel is reported stale. When no pair agrees, the block raises a no-majority flag and keeps its previous output. When the set of channels that feeds the output changes, the output is slew-limited so that it moves toward the new value in bounded steps and does not jump.

Top module: `tmr_window_voter`

## Requirements
- R1: While reset is high, and after it until the first vote, vote_out, ch_fault, ch_stale, no_major and vote_vld are all zero.
- R2: vote_vld is high for exactly one cycle. It rises on the clock edge after the edge that captured the last of the three channel strobes of a round, and it does not rise while any channel is still missing before the timeout.
- R3: Two present channels agree when the absolute difference of their unsigned values is less than or equal to tol. A difference of exactly tol counts as agreement.
- R4: When all three channels are present and at least two of the three pairs agree, the target is the median of the three values and ch_fault is 3'b000.
- R5: When exactly one pair agrees, the target is the floor of the mean of that pair. If the third channel is present, its ch_fault bit is set. Bit i of ch_fault and ch_stale refers to channel i (ch_val[i], ch_stb[i]).
- R6: When no pair agrees, no_major is 1 and vote_out keeps its previous value. A present channel's fault bit is set only when both other channels are present and disagree with it.
- R7: If a round is open and not all strobes have arrived, the vote fires TIMEOUT+1 edges after the edge that captured the first strobe. It uses only the present channels, and ch_stale is set for the absent ones.
- R8: When the set of channels that forms the target differs from the previous vote's set, vote_out moves toward the target by at most SLEW per vote. This continues on later votes until vote_out reaches the target. With an unchanged set and no ramp in progress, vote_out equals the target.
- R9: A repeated strobe on a channel within one round replaces that channel's earlier value.
- R10: The first vote after reset drives vote_out to the target directly, without slew limiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_val | input | 3×W | Per-channel sample values, unsigned |
| ch_stb | input | 3 | Per-channel one-cycle valid strobes |
| tol | input | W | Agreement window (inclusive) |
| vote_out | output | W | Voted value |
| vote_vld | output | 1 | One-cycle pulse when a vote result is registered |
| ch_fault | output | 3 | Channels voted out by both peers |
| ch_stale | output | 3 | Channels absent at timeout |
| no_major | output | 1 | No agreeing pair in the last vote |

## Verification
The vote is exercised with several input patterns, and each one separates one classification from the others. In the first, all three values sit inside the window, so the median is selected. In the second, two pairs agree but the outer pair does not; this shows that self-confidence keeps every channel in the vote. In the third, a single pair agrees with the lone channel sitting on either side, which checks the mean and the fault bit. In the fourth, the three values are fully spread out, so the output is held. A zero tolerance and a difference exactly equal to tol probe the window edges. A large jump combined with a change of membership shows the slew ramp step by step until it settles. Staggered and repeated strobes, together with rounds that close by timeout with one or two channels missing, separate the normal path from the timeout path and check the cycle in which each kind of vote appears.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;
  typedef enum logic [1:0] {
    VK_FULL = 2'd0,
    VK_PAIR = 2'd1,
    VK_NONE = 2'd2
  } vote_kind_e;
endpackage

// File: rtl/tmr_chan_latch.sv
module tmr_chan_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  input  logic [W-1:0] din,
  input  logic         clr,
  output logic         seen,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      data <= '0;
    end else if (stb) begin
      seen <= 1'b1;
      data <= din;
    end else if (clr) begin
      seen <= 1'b0;
    end
  end

  // R9
  latch_take_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> (seen && data == $past(din)));
endmodule

// File: rtl/tmr_round_ctrl.sv
module tmr_round_ctrl #(
  parameter int N       = 3,
  parameter int TIMEOUT = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] seen,
  output logic         fire
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] tmr_q;
  logic          all_in, any_in, expired;

  always_comb begin
    all_in  = &seen;
    any_in  = |seen;
    expired = any_in && (tmr_q == TW'(TIMEOUT));
    fire    = all_in || expired;
  end

  always_ff @(posedge clk) begin
    if (rst)                   tmr_q <= '0;
    else if (fire)             tmr_q <= '0;
    else if (any_in && !all_in) tmr_q <= tmr_q + 1'b1;
    else                       tmr_q <= '0;
  end

  // R7
  tmr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_q <= TW'(TIMEOUT));
endmodule

// File: rtl/tmr_agree_eval.sv
module tmr_agree_eval
  import tmr_vote_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [2:0][W-1:0] v,
  input  logic [2:0]        present,
  input  logic [W-1:0]      tol,
  output logic [W-1:0]      target,
  output vote_kind_e        kind,
  output logic [2:0]        used,
  output logic [2:0]        fault
);
  function automatic logic [W-1:0] adiff(input logic [W-1:0] x, input logic [W-1:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  // pair p joins channel p with channel (p+1)%3
  logic [2:0]        ag;
  logic [2:0][W-1:0] pmean;

  for (genvar p = 0; p < 3; p++) begin : g_pair
    localparam int J = (p + 1) % 3;
    logic [W:0] sum;
    always_comb begin
      ag[p]    = present[p] && present[J] && (adiff(v[p], v[J]) <= tol);
      sum      = {1'b0, v[p]} + {1'b0, v[J]};
      pmean[p] = sum[W:1];
    end
  end

  logic [W-1:0] lo01, hi01, mid;
  logic [1:0]   npairs;

  always_comb begin
    lo01   = (v[0] < v[1]) ? v[0] : v[1];
    hi01   = (v[0] < v[1]) ? v[1] : v[0];
    mid    = (hi01 < v[2]) ? hi01 : v[2];
    mid    = (mid > lo01) ? mid : lo01;
    npairs = 2'(ag[0]) + 2'(ag[1]) + 2'(ag[2]);

    fault[0] = (&present) && !ag[0] && !ag[2];
    fault[1] = (&present) && !ag[0] && !ag[1];
    fault[2] = (&present) && !ag[1] && !ag[2];

    kind   = VK_NONE;
    target = '0;
    used   = 3'b000;
    if (npairs >= 2'd2) begin
      kind   = VK_FULL;
      target = mid;
      used   = 3'b111;
    end else if (ag[0]) begin
      kind   = VK_PAIR;
      target = pmean[0];
      used   = 3'b011;
    end else if (ag[1]) begin
      kind   = VK_PAIR;
      target = pmean[1];
      used   = 3'b110;
    end else if (ag[2]) begin
      kind   = VK_PAIR;
      target = pmean[2];
      used   = 3'b101;
    end
  end
endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage
  import tmr_vote_pkg::*;
#(
  parameter int W    = 12,
  parameter int SLEW = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  vote_kind_e   kind,
  input  logic [W-1:0] target,
  input  logic [2:0]   used,
  input  logic [2:0]   fault_in,
  input  logic [2:0]   stale_in,
  output logic [W-1:0] vote_out,
  output logic         vote_vld,
  output logic [2:0]   ch_fault,
  output logic [2:0]   ch_stale,
  output logic         no_major
);
  localparam logic [W-1:0] STEP = W'(SLEW);

  logic         have_q, ramp_q;
  logic [2:0]   mask_q;
  logic         limit;
  logic [W-1:0] gap, nxt;

  always_comb begin
    limit = (have_q && (used != mask_q)) || ramp_q;
    gap   = (target > vote_out) ? (target - vote_out) : (vote_out - target);
    nxt   = target;
    if (limit && gap > STEP)
      nxt = (target > vote_out) ? (vote_out + STEP) : (vote_out - STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vote_out <= '0;
      vote_vld <= 1'b0;
      ch_fault <= '0;
      ch_stale <= '0;
      no_major <= 1'b0;
      have_q   <= 1'b0;
      ramp_q   <= 1'b0;
      mask_q   <= '0;
    end else begin
      vote_vld <= fire;
      if (fire) begin
        ch_fault <= fault_in;
        ch_stale <= stale_in;
        no_major <= (kind == VK_NONE);
        if (kind != VK_NONE) begin
          vote_out <= nxt;
          mask_q   <= used;
          have_q   <= 1'b1;
          ramp_q   <= limit && (nxt != target);
        end
      end
    end
  end

  // R6
  hold_on_split_chk: assert property (@(posedge clk) disable iff (rst)
    (vote_vld && no_major) |-> vote_out == $past(vote_out));

  // R5
  single_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (vote_vld && !no_major) |-> $countones(ch_fault) <= 1);

  // R7
  stale_fault_apart_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_stale & ch_fault) == 3'b000);

  // R8
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (vote_vld && $past(ramp_q)) |->
      (((vote_out > $past(vote_out)) ? (vote_out - $past(vote_out))
                                     : ($past(vote_out) - vote_out)) <= STEP));
endmodule

// File: rtl/tmr_window_voter.sv
module tmr_window_voter
  import tmr_vote_pkg::*;
#(
  parameter int W       = 12,
  parameter int TIMEOUT = 20,
  parameter int SLEW    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0][W-1:0] ch_val,
  input  logic [2:0]        ch_stb,
  input  logic [W-1:0]      tol,
  output logic [W-1:0]      vote_out,
  output logic              vote_vld,
  output logic [2:0]        ch_fault,
  output logic [2:0]        ch_stale,
  output logic              no_major
);
  localparam int NCH = 3;

  logic [NCH-1:0]        seen;
  logic [NCH-1:0][W-1:0] held;
  logic                  fire;
  logic [W-1:0]          target;
  vote_kind_e            kind;
  logic [2:0]            used, fault_c;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_chan_latch #(.W(W)) i_latch (
      .clk (clk),
      .rst (rst),
      .stb (ch_stb[c]),
      .din (ch_val[c]),
      .clr (fire),
      .seen(seen[c]),
      .data(held[c])
    );
  end

  tmr_round_ctrl #(.N(NCH), .TIMEOUT(TIMEOUT)) i_ctrl (
    .clk (clk),
    .rst (rst),
    .seen(seen),
    .fire(fire)
  );

  tmr_agree_eval #(.W(W)) i_eval (
    .v      (held),
    .present(seen),
    .tol    (tol),
    .target (target),
    .kind   (kind),
    .used   (used),
    .fault  (fault_c)
  );

  tmr_out_stage #(.W(W), .SLEW(SLEW)) i_out (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .kind    (kind),
    .target  (target),
    .used    (used),
    .fault_in(fault_c),
    .stale_in(~seen),
    .vote_out(vote_out),
    .vote_vld(vote_vld),
    .ch_fault(ch_fault),
    .ch_stale(ch_stale),
    .no_major(no_major)
  );

  // R2
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vote_vld |=> !vote_vld || $past(fire));
endmodule

// File: tb/test_tmr_window_voter.sv
module test_tmr_window_voter;
  localparam int W  = 12;
  localparam int TO = 20;
  localparam int SL = 16;
  localparam int NV = 9;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0][W-1:0] ch_val = '0;
  logic [2:0]        ch_stb = '0;
  logic [W-1:0]      tol = '0;
  logic [W-1:0]      vote_out;
  logic              vote_vld;
  logic [2:0]        ch_fault, ch_stale;
  logic              no_major;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  tmr_window_voter #(.W(W), .TIMEOUT(TO), .SLEW(SL)) i_tmr_window_voter (
    .clk(clk), .rst(rst), .ch_val(ch_val), .ch_stb(ch_stb), .tol(tol),
    .vote_out(vote_out), .vote_vld(vote_vld), .ch_fault(ch_fault),
    .ch_stale(ch_stale), .no_major(no_major)
  );

  // vectors: a, b, c, tol, expected out, fault, no_major
  localparam logic [W-1:0] VA[NV] = '{100, 200, 210, 220, 500, 230, 240, 250, 260};
  localparam logic [W-1:0] VB[NV] = '{105, 204, 214, 240, 600, 232, 248, 250, 259};
  localparam logic [W-1:0] VC[NV] = '{ 98, 210, 230, 226, 700, 231, 256, 251, 261};
  localparam logic [W-1:0] VT[NV] = '{ 10,  10,  10,  10,  10,  10,  10,   0,   2};
  localparam logic [W-1:0] VO[NV] = '{100, 204, 212, 223, 223, 231, 248, 250, 260};
  localparam logic [2:0]   VF[NV] = '{3'b000, 3'b000, 3'b100, 3'b010, 3'b111,
                                      3'b000, 3'b000, 3'b100, 3'b000};
  localparam logic         VN[NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all three strobes together; result sampled after the edge that registers it
  task automatic vote3(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c, input logic [W-1:0] t);
    ch_val = '{c, b, a};
    tol    = t;
    ch_stb = 3'b111;
    @(negedge clk);
    ch_stb = 3'b000;
    check("R2 no vote on capture edge", 32'(vote_vld), 0);
    @(negedge clk);
    check("R2 vote one edge later", 32'(vote_vld), 1);
  endtask

  task automatic partial(input logic [2:0] m, input logic [W-1:0] a, input logic [W-1:0] b);
    ch_val = '{12'd0, b, a};
    ch_stb = m;
    @(negedge clk);
    ch_stb = 3'b000;
    repeat (TO) @(negedge clk);
    check("R7 no vote before timeout", 32'(vote_vld), 0);
    @(negedge clk);
    check("R7 vote at timeout", 32'(vote_vld), 1);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 out in reset", 32'(vote_out), 0);
    check("R1 vld in reset", 32'(vote_vld), 0);
    check("R1 flags in reset", {ch_fault, ch_stale, no_major}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {vote_out, vote_vld, no_major}, 0);

    // table walk: R3 R4 R5 R6 R10
    for (int k = 0; k < NV; k++) begin
      vote3(VA[k], VB[k], VC[k], VT[k]);
      check($sformatf("R4/R5 out vec%0d", k), 32'(vote_out), 32'(VO[k]));
      check($sformatf("R5/R6 fault vec%0d", k), 32'(ch_fault), 32'(VF[k]));
      check($sformatf("R6 no_major vec%0d", k), 32'(no_major), 32'(VN[k]));
      @(negedge clk);
      check("R2 single pulse", 32'(vote_vld), 0);
    end

    // R9 R2 staggered strobes with overwrite on channel 0
    ch_val = '{12'd0, 12'd0, 12'd999}; ch_stb = 3'b001; @(negedge clk);
    ch_val = '{12'd0, 12'd0, 12'd262}; ch_stb = 3'b001; @(negedge clk);
    check("R2 waiting for peers", 32'(vote_vld), 0);
    ch_val = '{12'd0, 12'd261, 12'd0}; ch_stb = 3'b010; @(negedge clk);
    ch_val = '{12'd263, 12'd0, 12'd0}; ch_stb = 3'b100; @(negedge clk);
    ch_stb = 3'b000;
    check("R2 staggered capture edge", 32'(vote_vld), 0);
    @(negedge clk);
    check("R2 staggered vote", 32'(vote_vld), 1);
    check("R9 latest value used", 32'(vote_out), 262);

    // R8 slew after membership change: target 401 from 262
    vote3(12'd400, 12'd402, 12'd700, 12'd10);
    check("R8 first ramp step", 32'(vote_out), 278);
    check("R5 outlier flagged", 32'(ch_fault), 32'(3'b100));
    vote3(12'd400, 12'd402, 12'd700, 12'd10);
    check("R8 second ramp step", 32'(vote_out), 294);
    for (int k = 0; k < 6; k++) vote3(12'd400, 12'd402, 12'd700, 12'd10);
    check("R8 still ramping", 32'(vote_out), 390);
    vote3(12'd400, 12'd402, 12'd700, 12'd10);
    check("R8 settled", 32'(vote_out), 401);
    vote3(12'd406, 12'd408, 12'd700, 12'd10);
    check("R8 no ramp once settled", 32'(vote_out), 407);

    // R7 timeout with channel 2 missing
    partial(3'b011, 12'd400, 12'd402);
    check("R7 pair vote", 32'(vote_out), 401);
    check("R7 stale flag", 32'(ch_stale), 32'(3'b100));
    check("R7 no fault for absent", 32'(ch_fault), 0);
    check("R7 majority present", 32'(no_major), 0);

    // R7 R6 timeout with only channel 0
    partial(3'b001, 12'd50, 12'd0);
    check("R6 lone channel no majority", 32'(no_major), 1);
    check("R6 output held", 32'(vote_out), 401);
    check("R7 two stale", 32'(ch_stale), 32'(3'b110));
    check("R6 no fault without both peers", 32'(ch_fault), 0);

    // R10 reset then first vote is direct
    rst = 1'b1; @(negedge clk); @(negedge clk);
    check("R1 reset clears out", 32'(vote_out), 0);
    rst = 1'b0; @(negedge clk);
    vote3(12'd100, 12'd101, 12'd900, 12'd5);
    check("R10 first vote unslewed", 32'(vote_out), 100);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule